// File: doc/BRIEF.md
# DRAM Command Activity and Background Cycle Counter

This block watches the command stream a memory controller issues to a DRAM device, one command per clock, and accumulates the event counts that a trace-driven energy estimate needs. It keeps activate, precharge, read and write counts for every bank, so that interleaved traffic across banks stays separable. It also keeps refresh counts and data-bus transfer cycles, and it splits every counted cycle into one of two background kinds: at least one row open, or every bank closed.

On top of plain event counts, the block tracks row-buffer transactions per bank. It tags each transaction with whether it was opened by its own activate and whether it was closed by its own precharge, and counts the four combinations. It also sums transaction lengths in cycles, so that open-page and close-page traffic can both be costed from the actual spacing of commands. Precharge-all commands are treated as refresh preparation: the rows they close are charged to refresh and not to the transactions that were running.

Counting runs only inside an analysis window set by an enable input. A clear input zeroes the counters, and a snapshot strobe freezes a coherent copy that software reads one word at a time through a plain address/data port. Current, voltage and energy arithmetic is left to the consumer of the counts.

Top module: `dram_activity_counter`

## Requirements
- R1: After reset every bank is closed, all counters and all held copies are zero, and every read address returns zero.
- R2: cmd_op encodes 0 idle, 1 activate, 2 precharge one bank, 3 precharge all, 4 read, 5 write, 6 refresh. Activate, precharge, read and write add one to the counter of the bank on cmd_bank. Bank b's counters sit at addresses 16+4b (activate), 16+4b+1 (precharge), 16+4b+2 (read) and 16+4b+3 (write). A read or write with cmd_ap set also adds one to that bank's precharge counter and closes the bank.
- R3: Refresh adds one at address 0. Precharge-all adds the number of banks open at the start of that cycle at address 1, leaves every per-bank precharge counter unchanged, and closes all banks.
- R4: Each read adds BURST_LEN/2 at address 2, and each write adds BURST_LEN/2 at address 3.
- R5: Each counted cycle adds one at address 4 if any bank was open at the start of the cycle, otherwise one at address 5, never both.
- R6: A bank's transaction starts at the first read or write after its previous one ended, and later reads or writes join it. It is marked activated if an activate to that bank came since the previous end. It ends with a precharge on a bank precharge or an auto-precharge column command. It ends without a precharge on an activate to that bank, on a precharge-all, or after IDLE_GAP consecutive cycles with no command to that bank. Ends are counted at address 6 (neither), 7 (activated only), 8 (precharged only) and 9 (both).
- R7: Each ending transaction adds its length at address 10. The length runs from its activate (if activated) or its first column command through the ending cycle inclusive, plus BURST_LEN/2 when an auto-precharge ends it.
- R8: While win_en is low no counter changes, but bank and transaction state keep tracking commands.
- R9: clr zeroes every counter at the next edge, ahead of any increment in that cycle.
- R10: Every counter stops at its all-ones value instead of wrapping.
- R11: snap copies all counters, as they were before that edge, into held copies. rd_data shows the held copy at rd_addr, and addresses 11 to 15 and 16+4*NUM_BANKS upward read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| win_en | input | 1 | Analysis window enable |
| snap | input | 1 | Copy counters into held copies |
| cmd_op | input | 3 | Command code for this cycle |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cmd_ap | input | 1 | Auto-precharge flag on read or write |
| rd_addr | input | ADDR_W | Held-copy select |
| rd_data | output | CNT_W | Selected held copy |

## Verification
The embedded properties check on every cycle that counters never fall except on clear and stay pinned at all-ones. They also check that clear empties them, that a closed window freezes them, that exactly one background counter advances per counted cycle, and that a snapshot captures the prior value. Transaction classification and length depend on command order, idle timeouts and precharge-all attribution, so only the bench's scenarios show them. These include directed open, auto-precharge and timeout sequences and long random interleaved traffic that drives the counters into saturation.

// File: rtl/dram_activity_counter.sv
module dram_activity_counter #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 32,
  parameter int BURST_LEN = 8,
  parameter int IDLE_GAP  = 6,
  parameter int TLEN_W    = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         win_en,
  input  logic                         snap,
  input  logic [2:0]                   cmd_op,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic                         cmd_ap,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [CNT_W-1:0]             rd_data
);

  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int IDL_W     = $clog2(IDLE_GAP + 1);
  localparam int NCNT      = 16 + 4 * NUM_BANKS;
  localparam int INC_W     = CNT_W + TLEN_W + BANK_W + 2;

  localparam int I_REF    = 0;
  localparam int I_REFPRE = 1;
  localparam int I_RDCYC  = 2;
  localparam int I_WRCYC  = 3;
  localparam int I_ACTBG  = 4;
  localparam int I_PREBG  = 5;
  localparam int I_NANP   = 6;
  localparam int I_ANP    = 7;
  localparam int I_NAP    = 8;
  localparam int I_AP     = 9;
  localparam int I_TLEN   = 10;
  localparam int I_BANK   = 16;

  localparam logic [2:0] OP_ACT  = 3'd1;
  localparam logic [2:0] OP_PRE  = 3'd2;
  localparam logic [2:0] OP_PREA = 3'd3;
  localparam logic [2:0] OP_RD   = 3'd4;
  localparam logic [2:0] OP_WR   = 3'd5;
  localparam logic [2:0] OP_REF  = 3'd6;

  function automatic logic [TLEN_W-1:0] tadd(input logic [TLEN_W-1:0] x,
                                             input logic [TLEN_W-1:0] y);
    logic [TLEN_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[TLEN_W] ? '1 : s[TLEN_W-1:0];
  endfunction

  logic is_act, is_pre, is_prea, is_col, is_rd, is_wr, is_ref;
  assign is_act  = cmd_op == OP_ACT;
  assign is_pre  = cmd_op == OP_PRE;
  assign is_prea = cmd_op == OP_PREA;
  assign is_rd   = cmd_op == OP_RD;
  assign is_wr   = cmd_op == OP_WR;
  assign is_col  = is_rd | is_wr;
  assign is_ref  = cmd_op == OP_REF;

  logic [NUM_BANKS-1:0] open_q, cls_v, cls_a, cls_p;
  logic [TLEN_W-1:0]    cls_len [NUM_BANKS];

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic hit, open_r, actp_r, pend_r, pact_r;
    logic open_n, actp_n, pend_n, pact_n, v, a, p, anew;
    logic [TLEN_W-1:0] tlen_r, tlen_n, tnx, tcur, len;
    logic [IDL_W-1:0]  idl_r, idl_n;

    assign hit  = cmd_bank == BANK_W'(gb);
    assign tnx  = tadd(tlen_r, TLEN_W'(1));
    assign anew = pend_r ? pact_r : actp_r;
    assign tcur = (pend_r | actp_r) ? tnx : TLEN_W'(1);

    always_comb begin
      open_n = open_r; actp_n = actp_r; pend_n = pend_r; pact_n = pact_r;
      tlen_n = tlen_r; idl_n = idl_r;
      v = 1'b0; a = pact_r; p = 1'b0; len = '0;
      if (is_act && hit) begin
        v = pend_r; len = tnx;
        open_n = 1'b1; actp_n = 1'b1; pend_n = 1'b0; tlen_n = TLEN_W'(1); idl_n = '0;
      end else if ((is_pre && hit) || is_prea) begin
        v = pend_r; p = is_pre; len = tnx;
        open_n = 1'b0; actp_n = 1'b0; pend_n = 1'b0; tlen_n = '0; idl_n = '0;
      end else if (is_col && hit) begin
        if (cmd_ap) begin
          v = 1'b1; a = anew; p = 1'b1; len = tadd(tcur, TLEN_W'(BURST_CYC));
          open_n = 1'b0; actp_n = 1'b0; pend_n = 1'b0; tlen_n = '0; idl_n = '0;
        end else begin
          pend_n = 1'b1; pact_n = anew; actp_n = 1'b0; tlen_n = tcur; idl_n = '0;
        end
      end else if (pend_r && idl_r == IDL_W'(IDLE_GAP - 1)) begin
        v = 1'b1; len = tnx;
        pend_n = 1'b0; tlen_n = '0; idl_n = '0;
      end else begin
        if (pend_r | actp_r) tlen_n = tnx;
        if (pend_r) idl_n = idl_r + IDL_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_r <= 1'b0; actp_r <= 1'b0; pend_r <= 1'b0; pact_r <= 1'b0;
        tlen_r <= '0; idl_r <= '0;
      end else begin
        open_r <= open_n; actp_r <= actp_n; pend_r <= pend_n; pact_r <= pact_n;
        tlen_r <= tlen_n; idl_r <= idl_n;
      end
    end

    assign open_q[gb]  = open_r;
    assign cls_v[gb]   = v;
    assign cls_a[gb]   = a;
    assign cls_p[gb]   = p;
    assign cls_len[gb] = len;
  end

  logic [INC_W-1:0] inc   [NCNT];
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [CNT_W-1:0] cnt_d [NCNT];
  logic [CNT_W-1:0] snap_q[NCNT];

  always_comb begin
    for (int i = 0; i < NCNT; i++) inc[i] = '0;
    if (win_en) begin
      inc[I_ACTBG]  = INC_W'(|open_q);
      inc[I_PREBG]  = INC_W'(~|open_q);
      inc[I_REF]    = INC_W'(is_ref);
      inc[I_REFPRE] = is_prea ? INC_W'($countones(open_q)) : '0;
      inc[I_RDCYC]  = is_rd ? INC_W'(BURST_CYC) : '0;
      inc[I_WRCYC]  = is_wr ? INC_W'(BURST_CYC) : '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cmd_bank == BANK_W'(b)) begin
          inc[I_BANK + 4*b]     = INC_W'(is_act);
          inc[I_BANK + 4*b + 1] = INC_W'(is_pre | (is_col & cmd_ap));
          inc[I_BANK + 4*b + 2] = INC_W'(is_rd);
          inc[I_BANK + 4*b + 3] = INC_W'(is_wr);
        end
        if (cls_v[b]) begin
          if (!cls_p[b] && !cls_a[b]) inc[I_NANP] = inc[I_NANP] + INC_W'(1);
          if (!cls_p[b] &&  cls_a[b]) inc[I_ANP]  = inc[I_ANP]  + INC_W'(1);
          if ( cls_p[b] && !cls_a[b]) inc[I_NAP]  = inc[I_NAP]  + INC_W'(1);
          if ( cls_p[b] &&  cls_a[b]) inc[I_AP]   = inc[I_AP]   + INC_W'(1);
          inc[I_TLEN] = inc[I_TLEN] + INC_W'(cls_len[b]);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      logic [INC_W-1:0] s;
      s = INC_W'(cnt_q[i]) + inc[i];
      cnt_d[i] = (s >> CNT_W) != '0 ? '1 : s[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) begin
        cnt_q[i]  <= '0;
        snap_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (snap) snap_q[i] <= cnt_q[i];
        cnt_q[i] <= clr ? '0 : cnt_d[i];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCNT; i++)
      if (int'(rd_addr) == i) rd_data = snap_q[i];
  end

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_chk
    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt_q[gi] >= $past(cnt_q[gi])); // R10
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (&cnt_q[gi])) |=> (&cnt_q[gi])); // R10
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q[I_REF] == '0 && cnt_q[I_TLEN] == '0 && cnt_q[I_ACTBG] == '0)); // R9

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en && !clr) |=> ($stable(cnt_q[I_ACTBG]) && $stable(cnt_q[I_PREBG])
                           && $stable(cnt_q[I_TLEN]) && $stable(cnt_q[I_REF]))); // R8

  AST_BG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && !clr && !(&cnt_q[I_ACTBG]) && !(&cnt_q[I_PREBG]))
    |=> (cnt_q[I_ACTBG] + cnt_q[I_PREBG]) ==
        ($past(cnt_q[I_ACTBG]) + $past(cnt_q[I_PREBG]) + 1)); // R5

  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (snap_q[I_ACTBG] == $past(cnt_q[I_ACTBG])
              && snap_q[I_TLEN] == $past(cnt_q[I_TLEN]))); // R11

endmodule

// File: tb/tb_dram_activity_counter.sv
module tb_dram_activity_counter;
  localparam int NB   = 4;
  localparam int CW   = 12;
  localparam int BL   = 8;
  localparam int GAP  = 6;
  localparam int TW   = 16;
  localparam int AW   = 8;
  localparam int BC   = BL / 2;
  localparam int NCNT = 16 + 4 * NB;
  localparam int MAXC = (1 << CW) - 1;
  localparam int TMAX = (1 << TW) - 1;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, PREA = 3'd3,
                         RD = 3'd4, WR = 3'd5, REF = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, win_en = 1'b0, snap = 1'b0, cmd_ap = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [$clog2(NB)-1:0] cmd_bank = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;

  bit m_open[NB], m_actp[NB], m_pend[NB], m_pact[NB];
  int m_tlen[NB], m_idl[NB];
  int m_cnt[NCNT], m_snap[NCNT];

  always #10 clk = ~clk;

  dram_activity_counter #(.NUM_BANKS(NB), .CNT_W(CW), .BURST_LEN(BL), .IDLE_GAP(GAP),
                          .TLEN_W(TW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .win_en(win_en), .snap(snap),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic int tmin(int x, int m);
    return (x > m) ? m : x;
  endfunction

  function automatic string reqtag(int a);
    if (a >= NCNT) return "R11";
    if (a >= 16) return "R2";
    if (a <= 1) return "R3";
    if (a <= 3) return "R4";
    if (a <= 5) return "R5";
    if (a <= 9) return "R6";
    if (a == 10) return "R7";
    return "R11";
  endfunction

  task automatic model_step(input logic [2:0] op, input int bk, input bit ap,
                            input bit en, input bit cl, input bit sn);
    int inc[NCNT];
    int nopen;
    bit anyo;
    for (int i = 0; i < NCNT; i++) inc[i] = 0;
    nopen = 0;
    for (int b = 0; b < NB; b++) nopen += m_open[b];
    anyo = nopen != 0;
    if (en) begin
      if (anyo) inc[4] = 1; else inc[5] = 1;
      if (op == REF) inc[0] = 1;
      if (op == PREA) inc[1] = nopen;
      if (op == RD) begin inc[2] = BC; inc[16 + 4*bk + 2] = 1; end
      if (op == WR) begin inc[3] = BC; inc[16 + 4*bk + 3] = 1; end
      if (op == ACT) inc[16 + 4*bk] = 1;
      if (op == PRE || ((op == RD || op == WR) && ap)) inc[16 + 4*bk + 1] = 1;
    end
    for (int b = 0; b < NB; b++) begin
      bit hit, v, a, p;
      int tnx, tcur, len;
      hit = (bk == b);
      tnx = tmin(m_tlen[b] + 1, TMAX);
      v = 0; a = m_pact[b]; p = 0; len = 0;
      if (op == ACT && hit) begin
        v = m_pend[b]; len = tnx;
        m_open[b] = 1; m_actp[b] = 1; m_pend[b] = 0; m_tlen[b] = 1; m_idl[b] = 0;
      end else if ((op == PRE && hit) || op == PREA) begin
        v = m_pend[b]; p = (op == PRE); len = tnx;
        m_open[b] = 0; m_actp[b] = 0; m_pend[b] = 0; m_tlen[b] = 0; m_idl[b] = 0;
      end else if ((op == RD || op == WR) && hit) begin
        bit anew;
        anew = m_pend[b] ? m_pact[b] : m_actp[b];
        tcur = (m_pend[b] || m_actp[b]) ? tnx : 1;
        if (ap) begin
          v = 1; a = anew; p = 1; len = tmin(tcur + BC, TMAX);
          m_open[b] = 0; m_actp[b] = 0; m_pend[b] = 0; m_tlen[b] = 0; m_idl[b] = 0;
        end else begin
          m_pend[b] = 1; m_pact[b] = anew; m_actp[b] = 0; m_tlen[b] = tcur; m_idl[b] = 0;
        end
      end else if (m_pend[b] && m_idl[b] == GAP - 1) begin
        v = 1; len = tnx;
        m_pend[b] = 0; m_tlen[b] = 0; m_idl[b] = 0;
      end else begin
        if (m_pend[b] || m_actp[b]) m_tlen[b] = tnx;
        if (m_pend[b]) m_idl[b]++;
      end
      if (v && en) begin
        inc[6 + 2*p + a]++;
        inc[10] += len;
      end
    end
    if (sn) for (int i = 0; i < NCNT; i++) m_snap[i] = m_cnt[i];
    for (int i = 0; i < NCNT; i++) m_cnt[i] = cl ? 0 : tmin(m_cnt[i] + inc[i], MAXC);
  endtask

  task automatic cyc(input logic [2:0] op, input int bk, input bit ap, input bit en,
                     input bit cl, input bit sn, input bit chk, input int addr,
                     input int expv, input string tag);
    @(negedge clk);
    cmd_op = op; cmd_bank = bk[$clog2(NB)-1:0]; cmd_ap = ap;
    win_en = en; clr = cl; snap = sn; rd_addr = addr[AW-1:0];
    #1;
    if (chk) begin
      checks++;
      if (int'(rd_data) != expv) begin
        errors++;
        $display("FAIL %s addr %0d: actual %0d expected %0d", tag, addr, rd_data, expv);
      end
    end
    model_step(op, bk, ap, en, cl, sn);
  endtask

  task automatic cmd(input logic [2:0] op, input int bk, input bit ap);
    cyc(op, bk, ap, 1, 0, 0, 0, 0, 0, "");
  endtask

  task automatic hand(input int addr, input int expv, input string tag);
    cyc(NOP, 0, 0, 1, 0, 0, 1, addr, expv, tag);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < NCNT + 3; a++)
      cyc(NOP, 0, 0, 1, 0, 0, 1, a, (a < NCNT) ? m_snap[a] : 0, {tag, " ", reqtag(a)});
    cyc(NOP, 0, 0, 1, 0, 0, 1, 255, 0, {tag, " R11 unmapped"});
  endtask

  task automatic rand_cycle(input bit allow_clr, input bit en_bias);
    int r;
    logic [2:0] op;
    bit en;
    r = $urandom_range(0, 99);
    if (r < 30) op = NOP;
    else if (r < 45) op = ACT;
    else if (r < 55) op = PRE;
    else if (r < 58) op = PREA;
    else if (r < 76) op = RD;
    else if (r < 94) op = WR;
    else op = REF;
    en = en_bias ? 1'b1 : ($urandom_range(0, 99) < 85);
    cyc(op, $urandom_range(0, NB - 1), $urandom_range(0, 3) == 0, en,
        allow_clr && ($urandom_range(0, 149) == 0), $urandom_range(0, 49) == 0,
        0, 0, 0, "");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_actp[b] = 0; m_pend[b] = 0; m_pact[b] = 0; m_tlen[b] = 0; m_idl[b] = 0;
    end
    for (int i = 0; i < NCNT; i++) begin m_cnt[i] = 0; m_snap[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    read_all("R1 reset");

    // R6 R7 R5: activate, read, precharge on bank 1
    cyc(NOP, 0, 0, 1, 1, 0, 0, 0, 0, "");
    cmd(ACT, 1, 0); cmd(NOP, 0, 0); cmd(RD, 1, 0); cmd(NOP, 0, 0); cmd(NOP, 0, 0);
    cmd(PRE, 1, 0);
    cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
    hand(9, 1, "R6 AP class");
    hand(10, 6, "R7 length");
    hand(4, 5, "R5 active background");
    hand(5, 1, "R5 precharged background");
    hand(2, BC, "R4 read cycles");
    hand(21, 1, "R2 bank1 precharge");
    read_all("R6 directed");

    // R6 R7 R3: idle timeout, auto-precharge, precharge-all
    cyc(NOP, 0, 0, 1, 1, 0, 0, 0, 0, "");
    cmd(RD, 2, 0);
    repeat (GAP) cmd(NOP, 0, 0);
    cmd(ACT, 2, 0); cmd(RD, 2, 1);
    cmd(ACT, 0, 0); cmd(ACT, 3, 0); cmd(PREA, 0, 0); cmd(REF, 0, 0);
    cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
    hand(6, 1, "R6 timeout NANP");
    hand(9, 1, "R6 auto-precharge AP");
    hand(10, 13, "R7 length sum");
    hand(1, 2, "R3 refresh precharges");
    hand(17, 0, "R3 bank0 precharge untouched");
    hand(25, 1, "R2 bank2 auto-precharge");
    hand(0, 1, "R3 refresh count");
    read_all("R3 directed");

    // R8: window closed while commands run, state still tracked
    cyc(NOP, 0, 0, 1, 1, 0, 0, 0, 0, "");
    cyc(ACT, 1, 0, 0, 0, 0, 0, 0, 0, "");
    cyc(RD, 1, 0, 0, 0, 0, 0, 0, 0, "");
    repeat (3) cyc(NOP, 0, 0, 0, 0, 0, 0, 0, 0, "");
    cmd(PRE, 1, 0);
    cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
    hand(4, 1, "R8 background gated");
    hand(20, 0, "R8 activate gated");
    hand(22, 0, "R8 read gated");
    hand(9, 1, "R8 class after window");
    hand(10, 6, "R8 length spans window");

    // R9: clear in the same cycle as a command
    cmd(ACT, 0, 0);
    cyc(RD, 0, 0, 1, 1, 0, 0, 0, 0, "");
    cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
    hand(18, 0, "R9 clear beats increment");
    hand(16, 0, "R9 clear");

    // random interleaved traffic
    for (int blk = 0; blk < 6; blk++) begin
      for (int k = 0; k < 300; k++) rand_cycle(1, 0);
      cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
      read_all("R11 random");
    end

    // R10: long window without clear drives counters to saturation
    cyc(NOP, 0, 0, 1, 1, 0, 0, 0, 0, "");
    for (int k = 0; k < 9000; k++) rand_cycle(0, 1);
    cyc(NOP, 0, 0, 1, 0, 1, 0, 0, 0, "");
    hand(4 + (m_snap[5] > m_snap[4]), MAXC, "R10 saturated background");
    read_all("R10 saturation");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule